// File: doc/BRIEF.md
# Counter-Ramp ADC Controller

This block is the digital half of a counting analog-to-digital converter. It owns a binary counter whose value is driven straight onto the code input of an external DAC. An external comparator returns one bit that is HIGH while the DAC output is still below the analog input. The block compares nothing itself. It only reacts to that bit, one clock at a time.

Raising `start` clears the counter and drops `eoc`. The counter stays at zero for as long as `start` is held high. Once `start` returns low, the counter steps up by one on every clock while the comparator bit stays HIGH. It stops when the bit goes LOW, or when it reaches all ones. At that point the final count is copied to `result` and `eoc` is raised. Both then hold until the next start.

The conversion time therefore depends on the input level. It is at most 2^N−1 clocks, and about 2^(N−1) clocks on average. None of the pins carries a stream of data, so there is no valid/ready handshake and no back-pressure. `result` is a level that remains valid for as long as `eoc` is high. A consumer may read it at any time in that window.

Top module: `ramp_adc_ctrl`

## Requirements
- R1: During and after a synchronous active-low reset, `dac_code`, `result` and `eoc` are all zero.
- R2: On every clock edge that samples `start` high, `dac_code` becomes zero and `eoc` becomes low. No counting happens while `start` stays high.
- R3: After `start` has been sampled low, each clock edge that sees `cmp_below` HIGH with no conversion finished raises `dac_code` by exactly one.
- R4: The first edge that sees `cmp_below` LOW during a conversion holds `dac_code`, raises `eoc` and loads `result` with that same code.
- R5: With a comparator that reports HIGH exactly when `dac_code` is less than a level v, let k be the first edge that samples `start` low. Then `eoc` rises at edge k+min(v, 2^N−1), and `result` equals min(v, 2^N−1).
- R6: If the count reaches all ones while `cmp_below` is still HIGH, the conversion ends at full scale. `eoc` is raised and the counter never wraps to zero.
- R7: `result` changes only on the edge where `eoc` rises. It keeps the last completed value through a later conversion until that conversion finishes.
- R8: A `start` that arrives in the middle of a conversion abandons it and begins a new one from zero.
- R9: Once `eoc` is high, changes of `cmp_below` have no effect: `dac_code`, `result` and `eoc` stay fixed until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Start command; the count is held at zero while high |
| cmp_below | input | 1 | Comparator bit, HIGH while the DAC output is below the analog input |
| dac_code | output | N | Counter value driven to the external DAC |
| result | output | N | Last completed conversion value |
| eoc | output | 1 | End of conversion; high from completion until the next start |

## Verification
`dac_code` is registered, so it moves one edge after the comparator bit that caused the move. `eoc` and `result` change on the same edge, with no further delay. The bench drives every input at the falling clock edge and samples every output at the next falling edge. It counts rising edges from the first edge that sees `start` low and expects `eoc` exactly at edge min(v, 2^N−1). The bench's comparator model is combinational on `dac_code`, so each edge sees the comparator bit for the current code.

// File: rtl/ramp_adc_pkg.sv
package ramp_adc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RAMP = 2'd1,
    ST_DONE = 2'd2
  } ramp_state_e;
endpackage

// File: rtl/ramp_adc_counter.sv
module ramp_adc_counter #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [N-1:0] count,
  output logic         at_max
);
  localparam logic [N-1:0] MAX = {N{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n)   count <= '0;
    else if (clr) count <= '0;
    else if (inc) count <= count + N'(1);
  end

  assign at_max = (count == MAX);
endmodule

// File: rtl/ramp_adc_fsm.sv
module ramp_adc_fsm
  import ramp_adc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic cmp_below,
  input  logic at_max,
  output logic clr,
  output logic inc,
  output logic fin
);
  ramp_state_e state_q, state_d;
  logic        ramping;

  assign ramping = (state_q == ST_RAMP) && !start;
  assign clr     = start;
  assign inc     = ramping && cmp_below && !at_max;
  assign fin     = ramping && (!cmp_below || at_max);

  always_comb begin
    state_d = state_q;
    if (start)    state_d = ST_RAMP;
    else if (fin) state_d = ST_DONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/ramp_adc_result.sv
module ramp_adc_result #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         fin,
  input  logic [N-1:0] count,
  output logic [N-1:0] result,
  output logic         eoc
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result <= '0;
      eoc    <= 1'b0;
    end else if (clr) begin
      eoc    <= 1'b0;
    end else if (fin) begin
      result <= count;
      eoc    <= 1'b1;
    end
  end
endmodule

// File: rtl/ramp_adc_ctrl.sv
module ramp_adc_ctrl #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         cmp_below,
  output logic [N-1:0] dac_code,
  output logic [N-1:0] result,
  output logic         eoc
);
  logic clr, inc, fin, at_max;

  ramp_adc_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .cmp_below(cmp_below),
    .at_max(at_max), .clr(clr), .inc(inc), .fin(fin)
  );

  ramp_adc_counter #(.N(N)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(clr), .inc(inc),
    .count(dac_code), .at_max(at_max)
  );

  ramp_adc_result #(.N(N)) u_res (
    .clk(clk), .rst_n(rst_n), .clr(clr), .fin(fin),
    .count(dac_code), .result(result), .eoc(eoc)
  );
endmodule

// File: rtl/ramp_adc_checker.sv
module ramp_adc_checker #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         cmp_below,
  input logic [N-1:0] dac_code,
  input logic [N-1:0] result,
  input logic         eoc
);
  localparam logic [N-1:0] MAX = {N{1'b1}};

  logic armed;
  always_ff @(posedge clk) begin
    if (!rst_n)     armed <= 1'b0;
    else if (start) armed <= 1'b1;
  end

  // R2
  p_clear_on_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (dac_code == '0 && !eoc));

  // R3
  p_step_by_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !start && !eoc && cmp_below && dac_code != MAX)
      |=> dac_code == $past(dac_code) + N'(1));

  // R4
  p_stop_on_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !start && !eoc && !cmp_below)
      |=> (eoc && dac_code == $past(dac_code)));

  // R4
  p_result_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
    eoc |-> result == dac_code);

  // R6
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && dac_code == MAX) |=> dac_code == MAX);

  // R7
  p_result_on_eoc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> $rose(eoc));

  // R9
  p_done_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc && !start) |=> (eoc && $stable(dac_code) && $stable(result)));
endmodule

bind ramp_adc_ctrl ramp_adc_checker #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .cmp_below(cmp_below),
  .dac_code(dac_code), .result(result), .eoc(eoc)
);

// File: tb/ramp_adc_ctrl_bench.sv
module ramp_adc_ctrl_bench;
  localparam int N   = 8;
  localparam int MAX = (1 << N) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         cmp_below;
  logic [N-1:0] dac_code, result;
  logic         eoc;
  int           vin = 0;
  int           checks = 0;
  int           errors = 0;
  bit           finished = 0;

  always #2 clk = ~clk;

  // comparator model: HIGH while DAC output is below the level
  assign cmp_below = (int'(dac_code) < vin);

  ramp_adc_ctrl #(.N(N)) u_ramp_adc_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .cmp_below(cmp_below),
    .dac_code(dac_code), .result(result), .eoc(eoc)
  );

  function automatic int expect_code(int v);
    return (v > MAX) ? MAX : v;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cycles(int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  // pulse start for len edges, ramp to completion, check timing and value
  task automatic convert(int v, int len, bit trace);
    int m;
    int exp;
    exp = expect_code(v);
    @(negedge clk);
    vin = v;
    start = 1'b1;
    cycles(len);
    check(dac_code == 0, "R2 code cleared", dac_code, 0);
    check(eoc == 1'b0, "R2 eoc low", eoc, 0);
    start = 1'b0;
    m = 0;
    forever begin
      cycles(1);
      if (eoc) break;
      if (trace) check(int'(dac_code) == m + 1, "R3 step", dac_code, m + 1);
      m++;
      if (m > MAX + 4) break;
    end
    check(m == exp, "R5 eoc edge", m, exp);
    check(int'(result) == exp, "R5 result", result, exp);
    check(int'(dac_code) == exp, "R4 code held", dac_code, exp);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int held;
    void'($urandom(32'd20240611));
    cycles(3);
    check(dac_code == 0, "R1 code", dac_code, 0);
    check(result == 0, "R1 result", result, 0);
    check(eoc == 1'b0, "R1 eoc", eoc, 0);
    rst_n = 1'b1;
    cycles(2);
    check(dac_code == 0 && !eoc, "R1 idle after reset", dac_code, 0);

    convert(37, 1, 1'b1);
    convert(0, 3, 1'b0);
    convert(1, 1, 1'b1);
    convert(MAX, 2, 1'b0);

    // R6: comparator never goes LOW
    convert(MAX + 40, 1, 1'b0);
    cycles(5);
    check(int'(dac_code) == MAX, "R6 no wrap", dac_code, MAX);
    check(eoc == 1'b1, "R6 eoc stays", eoc, 1);

    // R9: comparator flips after completion
    convert(90, 1, 1'b0);
    vin = 500;
    cycles(6);
    check(dac_code == 90, "R9 code fixed", dac_code, 90);
    check(result == 90 && eoc, "R9 result fixed", result, 90);
    vin = 0;
    cycles(3);
    check(dac_code == 90 && eoc, "R9 code fixed low", dac_code, 90);

    // R8 / R7: restart mid-conversion
    held = int'(result);
    vin = 200;
    start = 1'b1;
    cycles(1);
    start = 1'b0;
    cycles(50);
    check(!eoc, "R8 still converting", eoc, 0);
    check(int'(result) == held, "R7 result held during ramp", result, held);
    convert(30, 1, 1'b1);
    check(result == 30, "R8 restart value", result, 30);

    for (int i = 0; i < 24; i++) begin
      convert(int'($urandom_range(0, MAX + 8)), int'($urandom_range(1, 4)), 1'b0);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule